// File: doc/BRIEF.md
# Float-to-unsigned truncating converter

This block turns one IEEE-754 single-precision value into a 32-bit unsigned integer by truncation: the fractional part is simply dropped, so the result is always the integer nearest to zero. Next to the integer it returns a five-bit status vector and a one-bit summary that is high whenever any status bit is high. Updating an architectural status register from these bits is left to the surrounding pipeline.

A caller presents the operand on `in_data` with `in_valid` high for one cycle. One clock later `out_valid` rises and the result, status vector and summary bit are available from output registers. The operand is first sorted into a class: zero, below one, in range, too large, NaN or negative. In-range values go through a single left shift. Out-of-domain operands are handled by fixed rules. A NaN and any nonzero negative value both give zero with only the invalid bit set. Values at or above 2^32 saturate to all ones with invalid. A lost fraction is reported as inexact only when invalid is not raised.

Top module: `fp32_to_u32_trunc`

## Requirements
- R1: `out_valid` is high exactly one clock after a cycle with `in_valid` high. `out_result`, `out_flags` and `out_any` change only on such accepted inputs and hold their values on cycles without `in_valid`.
- R2: A positive finite operand below 2^32 gives the integer part of its value (for example, 3.75 gives 3, 2^31 gives 0x80000000 and 0x4F7FFFFF gives 0xFFFFFF00).
- R3: The inexact bit is set when nonzero fraction bits are discarded from a positive operand below 2^32, including positive values below one and positive subnormals, which give 0. Inexact is never set together with invalid.
- R4: A NaN of either sign, quiet or signalling, gives result 0 and a status vector with only invalid set.
- R5: Any nonzero negative operand that is not a NaN (negative normals, negative subnormals, negative infinity) gives result 0 and only invalid. Inexact is suppressed even when a fraction was lost.
- R6: A positive operand of 2^32 or more, including positive infinity, gives 0xFFFFFFFF and only invalid.
- R7: Positive and negative zero both give result 0 with every status bit and `out_any` clear.
- R8: `out_flags` is encoded as bit 4 invalid, bit 3 overflow, bit 2 divide-by-zero, bit 1 underflow, bit 0 inexact. The overflow, divide-by-zero and underflow bits are always 0 for this operation.
- R9: `out_any` equals the OR of the five status bits of the same result, and is 0 when no bit is set.
- R10: While `rst_n` is low, `out_valid`, `out_result`, `out_flags` and `out_any` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand strobe |
| in_data | input | 32 | Single-precision operand |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_result | output | 32 | Truncated unsigned integer |
| out_flags | output | 5 | Status: [4] invalid, [3] overflow, [2] divide-by-zero, [1] underflow, [0] inexact |
| out_any | output | 1 | OR of all status bits |

## Verification
The checker watches several properties on every cycle: the one-cycle strobe latency and the holding of outputs on idle cycles, the fixed results for NaN, negative, saturating and zero operands, the mutual exclusion of inexact and invalid, the constant-zero status bits and the summary bit. It cannot show the correct integer value of an in-range operand or whether inexact is set exactly when a fraction is lost. Only the bench's reference model can cover these, over directed boundary values such as 2^31, the largest in-range float and subnormals, and over random operands sent back-to-back and with gaps. The reset values are also covered only by the bench.

// File: rtl/fp2u_pkg.sv
package fp2u_pkg;

  // Operand class decided before any shifting takes place.
  typedef enum logic [2:0] {
    CLS_ZERO,
    CLS_TINY,
    CLS_FIT,
    CLS_BIG,
    CLS_NAN,
    CLS_NEG
  } cvt_class_e;

  // Status vector, MSB first: invalid, overflow, div-by-zero, underflow, inexact.
  typedef struct packed {
    logic invalid;
    logic overflow;
    logic div_zero;
    logic underflow;
    logic inexact;
  } cvt_flags_t;

  localparam int FLAG_W = 5;

endpackage

// File: rtl/fp2u_classify.sv
module fp2u_classify #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int INT_W = 32,
  localparam int SH_W = $clog2(INT_W)
) (
  input  logic [EXP_W+MAN_W:0]    raw_i,
  output fp2u_pkg::cvt_class_e    cls_o,
  output logic [SH_W-1:0]         shamt_o,
  output logic [MAN_W:0]          sig_o
);
  import fp2u_pkg::*;

  localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
  localparam int LIMIT = BIAS + INT_W;

  logic             sgn;
  logic [EXP_W-1:0] ex;
  logic [MAN_W-1:0] mn;

  assign sgn = raw_i[EXP_W+MAN_W];
  assign ex  = raw_i[EXP_W+MAN_W-1:MAN_W];
  assign mn  = raw_i[MAN_W-1:0];

  function automatic logic exp_all_ones(input logic [EXP_W-1:0] e);
    return &e;
  endfunction

  function automatic cvt_class_e sort_operand(input logic s,
                                              input logic [EXP_W-1:0] e,
                                              input logic [MAN_W-1:0] m);
    if (exp_all_ones(e) && (m != '0))  return CLS_NAN;
    if ((e == '0) && (m == '0))        return CLS_ZERO;
    if (s)                             return CLS_NEG;
    if (int'(e) >= LIMIT)              return CLS_BIG;
    if (int'(e) < BIAS)                return CLS_TINY;
    return CLS_FIT;
  endfunction

  // Left shift that places the hidden bit at the integer's weight.
  function automatic logic [SH_W-1:0] unbias(input logic [EXP_W-1:0] e);
    return SH_W'(int'(e) - BIAS);
  endfunction

  always_comb begin
    cls_o   = sort_operand(sgn, ex, mn);
    shamt_o = (cls_o == CLS_FIT) ? unbias(ex) : '0;
    sig_o   = {(ex != '0), mn};
  end

endmodule

// File: rtl/fp2u_align.sv
module fp2u_align #(
  parameter int MAN_W = 23,
  parameter int INT_W = 32,
  localparam int SH_W = $clog2(INT_W),
  localparam int WIN_W = MAN_W + INT_W
) (
  input  logic [MAN_W:0]      sig_i,
  input  logic [SH_W-1:0]     shamt_i,
  output logic [INT_W-1:0]    int_o,
  output logic                lost_o
);

  logic [WIN_W-1:0] window;

  // The window holds the significand with its binary point at MAN_W;
  // bits above the point form the integer, bits below are discarded.
  function automatic logic [WIN_W-1:0] place(input logic [MAN_W:0] s,
                                             input logic [SH_W-1:0] k);
    return WIN_W'(s) << k;
  endfunction

  always_comb begin
    window = place(sig_i, shamt_i);
    int_o  = window[WIN_W-1:MAN_W];
    lost_o = |window[MAN_W-1:0];
  end

endmodule

// File: rtl/fp2u_resolve.sv
module fp2u_resolve #(
  parameter int INT_W = 32
) (
  input  fp2u_pkg::cvt_class_e  cls_i,
  input  logic [INT_W-1:0]      int_i,
  input  logic                  lost_i,
  output logic [INT_W-1:0]      result_o,
  output fp2u_pkg::cvt_flags_t  flags_o
);
  import fp2u_pkg::*;

  function automatic logic [INT_W-1:0] pick_value(input cvt_class_e c,
                                                  input logic [INT_W-1:0] v);
    case (c)
      CLS_FIT: return v;
      CLS_BIG: return '1;
      default: return '0;
    endcase
  endfunction

  function automatic cvt_flags_t pick_flags(input cvt_class_e c, input logic lost);
    cvt_flags_t f;
    f = '0;
    case (c)
      CLS_NAN, CLS_NEG, CLS_BIG: f.invalid = 1'b1;
      CLS_TINY:                  f.inexact = 1'b1;
      CLS_FIT:                   f.inexact = lost;
      default:                   f = '0;
    endcase
    return f;
  endfunction

  always_comb begin
    result_o = pick_value(cls_i, int_i);
    flags_o  = pick_flags(cls_i, lost_i);
  end

endmodule

// File: rtl/fp32_to_u32_trunc.sv
module fp32_to_u32_trunc #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int INT_W = 32,
  localparam int SH_W = $clog2(INT_W)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic [EXP_W+MAN_W:0]        in_data,
  output logic                        out_valid,
  output logic [INT_W-1:0]            out_result,
  output logic [fp2u_pkg::FLAG_W-1:0] out_flags,
  output logic                        out_any
);
  import fp2u_pkg::*;

  cvt_class_e       cls;
  logic [SH_W-1:0]  shamt;
  logic [MAN_W:0]   sig;
  logic [INT_W-1:0] int_val;
  logic             frac_lost;
  logic [INT_W-1:0] nxt_result;
  cvt_flags_t       nxt_flags;
  logic [FLAG_W-1:0] nxt_flag_vec;

  logic              valid_q;
  logic [INT_W-1:0]  result_q;
  logic [FLAG_W-1:0] flags_q;
  logic              any_q;

  fp2u_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W)) u_classify (
    .raw_i   (in_data),
    .cls_o   (cls),
    .shamt_o (shamt),
    .sig_o   (sig)
  );

  fp2u_align #(.MAN_W(MAN_W), .INT_W(INT_W)) u_align (
    .sig_i   (sig),
    .shamt_i (shamt),
    .int_o   (int_val),
    .lost_o  (frac_lost)
  );

  fp2u_resolve #(.INT_W(INT_W)) u_resolve (
    .cls_i    (cls),
    .int_i    (int_val),
    .lost_i   (frac_lost),
    .result_o (nxt_result),
    .flags_o  (nxt_flags)
  );

  assign nxt_flag_vec = nxt_flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      result_q <= '0;
      flags_q  <= '0;
      any_q    <= 1'b0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) begin
        result_q <= nxt_result;
        flags_q  <= nxt_flag_vec;
        any_q    <= |nxt_flag_vec;
      end
    end
  end

  assign out_valid  = valid_q;
  assign out_result = result_q;
  assign out_flags  = flags_q;
  assign out_any    = any_q;

endmodule

// File: rtl/fp2u_checker.sv
module fp2u_checker #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int INT_W = 32
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        in_valid,
  input logic [EXP_W+MAN_W:0]        in_data,
  input fp2u_pkg::cvt_class_e        cls,
  input logic                        out_valid,
  input logic [INT_W-1:0]            out_result,
  input logic [fp2u_pkg::FLAG_W-1:0] out_flags,
  input logic                        out_any
);
  import fp2u_pkg::*;

  localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
  localparam int LIMIT = BIAS + INT_W;

  logic op_nan, op_big, op_zero;
  assign op_nan  = (&in_data[EXP_W+MAN_W-1:MAN_W]) && (in_data[MAN_W-1:0] != '0);
  assign op_big  = !in_data[EXP_W+MAN_W] && !op_nan &&
                   (int'(in_data[EXP_W+MAN_W-1:MAN_W]) >= LIMIT);
  assign op_zero = (in_data[EXP_W+MAN_W-1:0] == '0);

  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_result) && $stable(out_flags) && $stable(out_any)));

  assert_no_mixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_flags[4] |-> !out_flags[0]);

  assert_nan_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_nan) |=> (out_result == '0 && out_flags == 5'b10000));

  assert_negative_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cls == CLS_NEG) |=> (out_result == '0 && out_flags == 5'b10000));

  assert_saturate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_big) |=> (out_result == '1 && out_flags == 5'b10000));

  assert_zero_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_zero) |=> (out_result == '0 && out_flags == '0 && !out_any));

  assert_unused_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_flags[3:1] == 3'b000);

  assert_summary_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_any == (|out_flags));

endmodule

bind fp32_to_u32_trunc fp2u_checker #(.EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_data    (in_data),
  .cls        (cls),
  .out_valid  (out_valid),
  .out_result (out_result),
  .out_flags  (out_flags),
  .out_any    (out_any)
);

// File: tb/fp32_to_u32_trunc_test.sv
`timescale 1ns/1ps
module fp32_to_u32_trunc_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic [31:0] out_result;
  logic [4:0]  out_flags;
  logic        out_any;

  always #2.5 clk = ~clk;

  fp32_to_u32_trunc uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .out_valid  (out_valid),
    .out_result (out_result),
    .out_flags  (out_flags),
    .out_any    (out_any)
  );

  typedef struct {
    logic [31:0] din;
    logic [31:0] res;
    logic [4:0]  fl;
    string       tag;
  } exp_item_t;

  exp_item_t sb[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  bit have_last = 1'b0;
  exp_item_t last;

  localparam logic [4:0] F_INV = 5'b10000;
  localparam logic [4:0] F_INX = 5'b00001;

  // Reference written from the requirements: classify by comparisons,
  // then rebuild the integer by explicit shifts on a 64-bit magnitude.
  function automatic void ref_conv(input logic [31:0] b,
                                   output logic [31:0] r, output logic [4:0] f);
    int e;
    longint unsigned mag, back;
    int k;
    e = int'(b[30:23]);
    r = '0;
    f = '0;
    if (e == 255 && b[22:0] != 0)        f = F_INV;           // R4
    else if (e == 0 && b[22:0] == 0)     f = '0;              // R7
    else if (b[31])                      f = F_INV;           // R5
    else if (e >= 127 + 32)              begin r = 32'hFFFF_FFFF; f = F_INV; end // R6
    else if (e < 127)                    f = F_INX;           // R3
    else begin                                                // R2
      mag = {40'd0, 1'b1, b[22:0]};
      k = e - 150;
      if (k >= 0) r = 32'(mag << k);
      else begin
        r = 32'(mag >> (-k));
        back = (mag >> (-k)) << (-k);
        if (back != mag) f = F_INX;
      end
    end
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  task automatic send(input logic [31:0] b, input string tag);
    exp_item_t it;
    it.din = b;
    it.tag = tag;
    ref_conv(b, it.res, it.fl);
    in_valid = 1'b1;
    in_data  = b;
    sb.push_back(it);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    for (int i = 0; i < n; i++) begin
      in_data = $urandom;   // ignored while in_valid is low (R1)
      @(negedge clk);
    end
  endtask

  function automatic logic [31:0] rand_float();
    logic [31:0] v;
    v = $urandom;
    v[30:23] = 8'(110 + $urandom_range(0, 55));
    if ($urandom_range(0, 3) != 0) v[31] = 1'b0;
    return v;
  endfunction

  // Monitor: compares each result against the scoreboard head.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        if (sb.size() == 0) begin
          check(1'b0, "R1", "unexpected out_valid", {31'd0, out_valid}, 32'd0);
        end else begin
          exp_item_t it;
          it = sb.pop_front();
          check(out_result == it.res, it.tag, $sformatf("result for %h", it.din), out_result, it.res);
          check(out_flags == it.fl, (it.fl == '0) ? it.tag : "R8", $sformatf("flags for %h", it.din),
                {27'd0, out_flags}, {27'd0, it.fl});
          check(out_any == (|it.fl), "R9", $sformatf("any for %h", it.din),
                {31'd0, out_any}, {31'd0, |it.fl});
          last = it;
          have_last = 1'b1;
        end
      end else if (have_last) begin
        check(out_result == last.res && out_flags == last.fl, "R1", "hold on idle",
              out_result, last.res);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check(out_valid == 1'b0, "R10", "out_valid in reset", {31'd0, out_valid}, 32'd0);
    check(out_result == '0,  "R10", "out_result in reset", out_result, 32'd0);
    check(out_flags == '0 && out_any == 1'b0, "R10", "flags in reset", {27'd0, out_flags}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    send(32'h4070_0000, "R2");  // 3.75 -> 3, inexact
    send(32'h3F80_0000, "R2");  // 1.0
    send(32'h4F00_0000, "R2");  // 2^31
    send(32'h4F7F_FFFF, "R2");  // largest below 2^32
    send(32'h47F1_2065, "R2");  // 123456.79
    idle(2);
    send(32'h3F00_0000, "R3");  // 0.5
    send(32'h0000_0001, "R3");  // smallest subnormal
    send(32'h3F7F_FFFF, "R3");  // just below one
    idle(1);
    send(32'h7FC0_0000, "R4");
    send(32'hFFC0_0001, "R4");
    send(32'h7F80_0001, "R4");
    send(32'hBF80_0000, "R5");  // -1.0
    send(32'hBF00_0000, "R5");  // -0.5, fraction lost but no inexact
    send(32'hFF80_0000, "R5");  // -inf
    send(32'h8000_0001, "R5");  // negative subnormal
    send(32'h4F80_0000, "R6");  // 2^32
    send(32'h7F80_0000, "R6");  // +inf
    send(32'h7F7F_FFFF, "R6");
    send(32'h0000_0000, "R7");
    send(32'h8000_0000, "R7");
    idle(3);

    for (int i = 0; i < 300; i++) send(rand_float(), "R2");
    for (int i = 0; i < 300; i++) begin
      send(rand_float(), "R3");
      idle($urandom_range(0, 2));
    end
    idle(1);
    for (int i = 0; i < 50 && sb.size() != 0; i++) @(negedge clk);
    idle(3);
    if (sb.size() != 0)
      check(1'b0, "R1", "results outstanding", 32'(sb.size()), 32'd0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL R1 watchdog expired: actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule